// File: doc/BRIEF.md
# Activity-Monitor Read-Trap Control Register

This block holds a 64-bit hypervisor-level control word. The word selects which guest reads of activity-monitor registers are diverted to the hypervisor. The block makes two kinds of decision. The first covers system-register reads and writes of the control word itself. Each one is judged against the feature strap, the current exception level, the effective nested-virtualization bits and the secure-monitor trap enable. The result is one of five: the access completes, it is undefined, it traps to EL2, it traps to EL3, or it is redirected to a memory slot at a fixed offset.

The second covers guest reads of activity-monitor registers from EL0 or EL1. Each read names a register class and an index. The block picks the control bit for that register and combines it with the virtualization context. The read is then either trapped to EL2 or allowed to go ahead.

A request is presented for one cycle with `req_valid` high. The block has no back-pressure: it accepts one request in every cycle and keeps nothing queued. Exactly one registered outcome pulse appears in the cycle after the request, or none in the cases named below. Both trap kinds report syndrome class 0x18.

Top module: `actmon_trap_ctl`

## Requirements
- R1: After reset the control word is all zeros. All outcome outputs, `out_ec`, `out_redir_off` and `out_rdata` are zero.
- R2: Only bits 49:17 and 4:0 of the control word can be written. All other bits always read as zero, so writing all ones and reading back gives 0x0003_FFFF_FFFE_001F.
- R3: A control-word access (`req_kind`=0, encoding matching) made while `feat_present`=0 gives `out_undef`, whatever the level.
- R4: A control-word access from EL0 (`req_el`=0) gives `out_undef`.
- R5: A control-word access from EL1 depends on `nv_bits`:
  - bits [2] and [0] both set gives `out_redir` with `out_redir_off`=0x1E8;
  - otherwise bit [0] set gives `out_trap_el2` with `out_ec`=0x18;
  - otherwise `out_undef`.
  A redirected or trapped write leaves the control word unchanged.
- R6: A control-word access from EL2 depends on the monitor:
  - `el3_present`=1 with `sm_trap_en`=0 gives `out_undef` when `mon_undef_first` or `mon_undef` is set;
  - the same case with both of those clear gives `out_trap_el3` with `out_ec`=0x18;
  - in every other EL2 case `out_pass`, and the access goes ahead directly.
- R7: A control-word access from EL3 always gives `out_pass`. A write loads the control word. A read returns the word in `out_rdata` in the outcome cycle. `out_rdata` is zero whenever no direct read completes.
- R8: A guest read (`req_kind`=1) uses a control bit chosen by `gr_class`. The mapping is:
  - class 0 uses bit 0;
  - class 1 with index i<4 uses bit 1+i;
  - class 2 uses bit 17;
  - class 3 with index x uses bit 18+2x;
  - class 4 with index x uses bit 19+2x.
  Class 1 with i>=4, and classes 5 to 7, have no control bit. A guest read from EL0/EL1 whose bit is 1 and whose context is valid gives `out_trap_el2` with `out_ec`=0x18. Otherwise it gives `out_pass`.
- R9: The guest-read context is valid only when all four conditions hold:
  - `el2_en`=1;
  - not (`hcr_e2h`=1 and `hcr_tge`=1);
  - `el1_aa64`=1;
  - `el3_present`=0 or `sm_trap_en`=1.
  A guest read at `req_el`>=2 always gives `out_pass`.
- R10: A guest read with `hi_prio_exc`=1 gives no outcome at all.
- R11: Outcomes are registered one cycle after the request. At most one outcome is asserted per request, and none is asserted in a cycle that follows no request.
- R12: A control-word access whose `req_enc` differs from 16'b11_100_0011_0001_110 gives no outcome and leaves the control word unchanged. The encoding fields, from MSB down, are op0[2], op1[3], CRn[4], CRm[4] and op2[3].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| feat_present | input | 1 | Feature strap |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 1 | 0 = control-word access, 1 = guest monitor read |
| req_write | input | 1 | Control-word access is a write |
| req_enc | input | 16 | System-register encoding of the access |
| req_wdata | input | 64 | Write data |
| req_el | input | 2 | Current exception level |
| gr_class | input | 3 | Guest read register class |
| gr_idx | input | 4 | Guest read register index |
| hi_prio_exc | input | 1 | Guest read already raises a higher-priority exception |
| el2_en | input | 1 | EL2 implemented and enabled in current security state |
| hcr_e2h | input | 1 | Effective host-mode bit |
| hcr_tge | input | 1 | Effective trap-general bit |
| el1_aa64 | input | 1 | EL1 runs the 64-bit execution state |
| nv_bits | input | 3 | Effective nested-virtualization bits |
| el3_present | input | 1 | EL3 exists |
| sm_trap_en | input | 1 | Monitor fine-grained trap enable |
| mon_undef_first | input | 1 | Undefined takes priority over the EL3 trap |
| mon_undef | input | 1 | Secure-debug undefined condition |
| out_pass | output | 1 | Access goes ahead directly |
| out_undef | output | 1 | Undefined instruction |
| out_trap_el2 | output | 1 | Trap to EL2 |
| out_trap_el3 | output | 1 | Trap to EL3 |
| out_redir | output | 1 | Redirect to memory |
| out_ec | output | 6 | Syndrome class for traps |
| out_redir_off | output | 12 | Memory offset for redirect |
| out_rdata | output | 64 | Read data of a direct read |

## Verification
Every outcome pulse, with its syndrome class, offset and read data, is due exactly one clock edge after the request is sampled. A write that completes changes the control word at that same edge, so the next request already sees the new value. The bench applies each request on a falling edge and compares all outputs on the following falling edge, before the next request is applied. It then updates its model word, which keeps each comparison tied to the single edge where the result is due. Idle cycles in between confirm that nothing is asserted without a request.

// File: rtl/actmon_pkg.sv
package actmon_pkg;
  localparam logic [2:0] GC_G0_EN  = 3'd0;
  localparam logic [2:0] GC_G0_CNT = 3'd1;
  localparam logic [2:0] GC_G1_EN  = 3'd2;
  localparam logic [2:0] GC_G1_CNT = 3'd3;
  localparam logic [2:0] GC_G1_TYP = 3'd4;

  typedef struct packed {
    logic pass;
    logic undef;
    logic trap2;
    logic trap3;
    logic redir;
  } outcome_t;
endpackage

// File: rtl/actmon_ctl_access.sv
module actmon_ctl_access
  import actmon_pkg::*;
#(
  parameter int ENC_W = 16,
  parameter logic [ENC_W-1:0] ENC = 16'b11_100_0011_0001_110
) (
  input  logic             valid_i,
  input  logic [ENC_W-1:0] enc_i,
  input  logic             feat_i,
  input  logic [1:0]       el_i,
  input  logic [2:0]       nv_i,
  input  logic             el3_present_i,
  input  logic             sm_en_i,
  input  logic             undef_first_i,
  input  logic             undef_i,
  output outcome_t         res_o
);
  logic hit;
  assign hit = valid_i && (enc_i == ENC);

  always_comb begin
    res_o = '0;
    if (hit) begin
      if (!feat_i) begin
        res_o.undef = 1'b1;
      end else begin
        case (el_i)
          2'd0: res_o.undef = 1'b1;
          2'd1: begin
            if (nv_i[2] && nv_i[0])  res_o.redir = 1'b1;
            else if (nv_i[0])        res_o.trap2 = 1'b1;
            else                     res_o.undef = 1'b1;
          end
          2'd2: begin
            if (el3_present_i && !sm_en_i) begin
              if (undef_first_i)     res_o.undef = 1'b1;
              else if (undef_i)      res_o.undef = 1'b1;
              else                   res_o.trap3 = 1'b1;
            end else begin
              res_o.pass = 1'b1;
            end
          end
          default: res_o.pass = 1'b1;
        endcase
      end
    end
  end

  // R4
  always_comb begin
    if (hit && feat_i && el_i == 2'd0) begin
      el0_undef_chk: assert (res_o.undef && !res_o.pass);
    end
  end
endmodule

// File: rtl/actmon_guest_decide.sv
module actmon_guest_decide
  import actmon_pkg::*;
#(
  parameter int REG_W = 64,
  parameter int G0_CNT = 4,
  parameter int G1_CNT = 16,
  parameter int G0_EN_BIT = 0,
  parameter int G0_CNT_LO = 1,
  parameter int G1_EN_BIT = 17,
  parameter int G1_LO = 18,
  parameter int IDX_W = 4
) (
  input  logic             valid_i,
  input  logic [REG_W-1:0] ctl_i,
  input  logic [2:0]       class_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [1:0]       el_i,
  input  logic             hi_prio_i,
  input  logic             el2_en_i,
  input  logic             e2h_i,
  input  logic             tge_i,
  input  logic             el1_aa64_i,
  input  logic             el3_present_i,
  input  logic             sm_en_i,
  output logic             trap_o,
  output logic             pass_o
);
  logic have_bit;
  int   pos;
  logic ctx_ok;
  logic low_el;

  always_comb begin
    have_bit = 1'b0;
    pos = 0;
    case (class_i)
      GC_G0_EN: begin
        have_bit = 1'b1;
        pos = G0_EN_BIT;
      end
      GC_G0_CNT: begin
        have_bit = int'(idx_i) < G0_CNT;
        pos = have_bit ? G0_CNT_LO + int'(idx_i) : 0;
      end
      GC_G1_EN: begin
        have_bit = 1'b1;
        pos = G1_EN_BIT;
      end
      GC_G1_CNT: begin
        have_bit = int'(idx_i) < G1_CNT;
        pos = have_bit ? G1_LO + 2 * int'(idx_i) : 0;
      end
      GC_G1_TYP: begin
        have_bit = int'(idx_i) < G1_CNT;
        pos = have_bit ? G1_LO + 2 * int'(idx_i) + 1 : 0;
      end
      default: begin
        have_bit = 1'b0;
        pos = 0;
      end
    endcase
  end

  assign ctx_ok = el2_en_i && !(e2h_i && tge_i) && el1_aa64_i &&
                  (!el3_present_i || sm_en_i);
  assign low_el = (el_i < 2'd2);
  assign trap_o = valid_i && !hi_prio_i && low_el && have_bit &&
                  ctl_i[pos] && ctx_ok;
  assign pass_o = valid_i && !hi_prio_i && !trap_o;
endmodule

// File: rtl/actmon_trap_ctl.sv
module actmon_trap_ctl
  import actmon_pkg::*;
#(
  parameter int REG_W = 64,
  parameter int ENC_W = 16,
  parameter logic [ENC_W-1:0] ENC = 16'b11_100_0011_0001_110,
  parameter int G0_CNT = 4,
  parameter int G1_CNT = 16,
  parameter int RSV_GAP = 12,
  parameter int EC_W = 6,
  parameter logic [EC_W-1:0] EC_SYS = 6'h18,
  parameter int OFF_W = 12,
  parameter logic [OFF_W-1:0] NV_OFF = 12'h1E8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               feat_present,
  input  logic               req_valid,
  input  logic               req_kind,
  input  logic               req_write,
  input  logic [ENC_W-1:0]   req_enc,
  input  logic [REG_W-1:0]   req_wdata,
  input  logic [1:0]         req_el,
  input  logic [2:0]         gr_class,
  input  logic [3:0]         gr_idx,
  input  logic               hi_prio_exc,
  input  logic               el2_en,
  input  logic               hcr_e2h,
  input  logic               hcr_tge,
  input  logic               el1_aa64,
  input  logic [2:0]         nv_bits,
  input  logic               el3_present,
  input  logic               sm_trap_en,
  input  logic               mon_undef_first,
  input  logic               mon_undef,
  output logic               out_pass,
  output logic               out_undef,
  output logic               out_trap_el2,
  output logic               out_trap_el3,
  output logic               out_redir,
  output logic [EC_W-1:0]    out_ec,
  output logic [OFF_W-1:0]   out_redir_off,
  output logic [REG_W-1:0]   out_rdata
);
  localparam int G0_EN_BIT = 0;
  localparam int G0_CNT_LO = G0_EN_BIT + 1;
  localparam int G1_EN_BIT = G0_CNT_LO + G0_CNT + RSV_GAP;
  localparam int G1_LO     = G1_EN_BIT + 1;
  localparam int G1_HI     = G1_LO + 2 * G1_CNT - 1;
  localparam int IDX_W     = 4;

  function automatic logic [REG_W-1:0] mk_mask();
    logic [REG_W-1:0] m;
    m = '0;
    for (int b = 0; b < REG_W; b++) begin
      if (b <= G0_CNT_LO + G0_CNT - 1) m[b] = 1'b1;
      if (b >= G1_EN_BIT && b <= G1_HI) m[b] = 1'b1;
    end
    return m;
  endfunction
  localparam logic [REG_W-1:0] WMASK = mk_mask();

  logic [REG_W-1:0] ctl_q;
  outcome_t         acc_res;
  outcome_t         nxt;
  logic             g_trap, g_pass;
  logic             acc_sel, g_sel;

  assign acc_sel = req_valid && !req_kind;
  assign g_sel   = req_valid && req_kind;

  actmon_ctl_access #(.ENC_W(ENC_W), .ENC(ENC)) i_access (
    .valid_i       (acc_sel),
    .enc_i         (req_enc),
    .feat_i        (feat_present),
    .el_i          (req_el),
    .nv_i          (nv_bits),
    .el3_present_i (el3_present),
    .sm_en_i       (sm_trap_en),
    .undef_first_i (mon_undef_first),
    .undef_i       (mon_undef),
    .res_o         (acc_res)
  );

  actmon_guest_decide #(
    .REG_W(REG_W), .G0_CNT(G0_CNT), .G1_CNT(G1_CNT),
    .G0_EN_BIT(G0_EN_BIT), .G0_CNT_LO(G0_CNT_LO),
    .G1_EN_BIT(G1_EN_BIT), .G1_LO(G1_LO), .IDX_W(IDX_W)
  ) i_guest (
    .valid_i       (g_sel),
    .ctl_i         (ctl_q),
    .class_i       (gr_class),
    .idx_i         (gr_idx),
    .el_i          (req_el),
    .hi_prio_i     (hi_prio_exc),
    .el2_en_i      (el2_en),
    .e2h_i         (hcr_e2h),
    .tge_i         (hcr_tge),
    .el1_aa64_i    (el1_aa64),
    .el3_present_i (el3_present),
    .sm_en_i       (sm_trap_en),
    .trap_o        (g_trap),
    .pass_o        (g_pass)
  );

  always_comb begin
    nxt = acc_res;
    if (g_sel) begin
      nxt = '0;
      nxt.trap2 = g_trap;
      nxt.pass  = g_pass;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q         <= '0;
      out_pass      <= 1'b0;
      out_undef     <= 1'b0;
      out_trap_el2  <= 1'b0;
      out_trap_el3  <= 1'b0;
      out_redir     <= 1'b0;
      out_ec        <= '0;
      out_redir_off <= '0;
      out_rdata     <= '0;
    end else begin
      out_pass      <= nxt.pass;
      out_undef     <= nxt.undef;
      out_trap_el2  <= nxt.trap2;
      out_trap_el3  <= nxt.trap3;
      out_redir     <= nxt.redir;
      out_ec        <= (nxt.trap2 || nxt.trap3) ? EC_SYS : '0;
      out_redir_off <= nxt.redir ? NV_OFF : '0;
      out_rdata     <= (acc_sel && acc_res.pass && !req_write) ? ctl_q : '0;
      if (acc_sel && acc_res.pass && req_write) begin
        ctl_q <= req_wdata & WMASK;
      end
    end
  end

  // R11
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_pass, out_undef, out_trap_el2, out_trap_el3, out_redir}));

  // R11
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_pass || out_undef || out_trap_el2 || out_trap_el3 || out_redir)
      |-> $past(req_valid));

  // R3
  no_feat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && !req_kind && req_enc == ENC && !feat_present)
      |-> out_undef);

  // R7
  el3_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && !req_kind && req_enc == ENC && feat_present &&
          req_el == 2'd3) |-> out_pass);

  // R12
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(ctl_q));

  // R2
  rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q & ~WMASK) == '0);

  // R9
  ctx_el2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && req_kind && !el2_en) |-> !out_trap_el2);

  // R10
  hi_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && req_kind && hi_prio_exc)
      |-> !(out_pass || out_trap_el2));
endmodule

// File: tb/test_actmon_trap_ctl.sv
module test_actmon_trap_ctl;
  localparam logic [15:0] ENC = 16'b11_100_0011_0001_110;
  localparam logic [63:0] MASK = 64'h0003_FFFF_FFFE_001F;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic feat_present = 1'b1;
  logic req_valid = 1'b0, req_kind = 1'b0, req_write = 1'b0;
  logic [15:0] req_enc = '0;
  logic [63:0] req_wdata = '0;
  logic [1:0] req_el = '0;
  logic [2:0] gr_class = '0;
  logic [3:0] gr_idx = '0;
  logic hi_prio_exc = 1'b0, el2_en = 1'b0, hcr_e2h = 1'b0, hcr_tge = 1'b0;
  logic el1_aa64 = 1'b0, el3_present = 1'b0, sm_trap_en = 1'b0;
  logic [2:0] nv_bits = '0;
  logic mon_undef_first = 1'b0, mon_undef = 1'b0;
  logic out_pass, out_undef, out_trap_el2, out_trap_el3, out_redir;
  logic [5:0] out_ec;
  logic [11:0] out_redir_off;
  logic [63:0] out_rdata;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [63:0] m_reg = '0;

  always #5 clk = ~clk;

  actmon_trap_ctl i_actmon_trap_ctl (.*);

  // outcome code: {pass, undef, trap2, trap3, redir}
  function automatic logic [4:0] exp_ctl();
    if (!req_valid || req_kind || req_enc != ENC) return 5'b00000;
    if (!feat_present) return 5'b01000;
    case (req_el)
      2'd0: return 5'b01000;
      2'd1: begin
        if (nv_bits[2] && nv_bits[0]) return 5'b00001;
        if (nv_bits[0]) return 5'b00100;
        return 5'b01000;
      end
      2'd2: begin
        if (el3_present && !sm_trap_en)
          return (mon_undef_first || mon_undef) ? 5'b01000 : 5'b00010;
        return 5'b10000;
      end
      default: return 5'b10000;
    endcase
  endfunction

  function automatic int ctl_bit();
    case (gr_class)
      3'd0: return 0;
      3'd1: return (gr_idx < 4) ? 1 + int'(gr_idx) : -1;
      3'd2: return 17;
      3'd3: return 18 + 2 * int'(gr_idx);
      3'd4: return 19 + 2 * int'(gr_idx);
      default: return -1;
    endcase
  endfunction

  function automatic bit ctx_good();
    return el2_en && !(hcr_e2h && hcr_tge) && el1_aa64 &&
           (!el3_present || sm_trap_en);
  endfunction

  function automatic logic [4:0] exp_guest();
    int b;
    if (hi_prio_exc) return 5'b00000;
    b = ctl_bit();
    if (req_el < 2 && b >= 0 && m_reg[b] && ctx_good()) return 5'b00100;
    return 5'b10000;
  endfunction

  function automatic string tag_of();
    if (!req_valid) return "R11";
    if (!req_kind) begin
      if (req_enc != ENC) return "R12";
      if (!feat_present) return "R3";
      case (req_el)
        2'd0: return "R4";
        2'd1: return "R5";
        2'd2: return "R6";
        default: return "R7";
      endcase
    end
    if (hi_prio_exc) return "R10";
    if (!ctx_good() || req_el >= 2) return "R9";
    return "R8";
  endfunction

  task automatic check(input string tag, input logic [87:0] act,
                       input logic [87:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // inputs are already set at a falling edge; results sampled at the next
  task automatic step();
    logic [4:0] eo;
    logic [5:0] eec;
    logic [11:0] eoff;
    logic [63:0] erd;
    string tag;
    eo = (req_valid && req_kind) ? exp_guest() : exp_ctl();
    eec = (eo[2] || eo[1]) ? 6'h18 : 6'h00;
    eoff = eo[0] ? 12'h1E8 : 12'h000;
    erd = (req_valid && !req_kind && eo[4] && !req_write) ? m_reg : 64'h0;
    tag = tag_of();
    @(negedge clk);
    check(tag,
          {out_pass, out_undef, out_trap_el2, out_trap_el3, out_redir,
           out_ec, out_redir_off, out_rdata},
          {eo, eec, eoff, erd});
    if (req_valid && !req_kind && eo[4] && req_write) m_reg = req_wdata & MASK;
  endtask

  task automatic ctl_op(input logic [1:0] el, input logic wr,
                        input logic [63:0] wd);
    req_valid = 1; req_kind = 0; req_enc = ENC; req_el = el;
    req_write = wr; req_wdata = wd;
    step();
  endtask

  initial begin
    int unused;
    unused = $urandom(32'h5eed_1234);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state of outputs
    check("R1", {out_pass, out_undef, out_trap_el2, out_trap_el3, out_redir,
                 out_ec, out_redir_off, out_rdata}, '0);
    // R1 control word reads zero
    feat_present = 1; el3_present = 1; sm_trap_en = 1;
    ctl_op(2'd3, 0, '0);
    // R2 reserved bits
    ctl_op(2'd3, 1, '1);
    ctl_op(2'd3, 0, '0);
    check("R2", m_reg, 64'h0003_FFFF_FFFE_001F);
    // R5 trapped write leaves word unchanged
    nv_bits = 3'b001;
    ctl_op(2'd1, 1, 64'h0);
    nv_bits = 3'b101;
    ctl_op(2'd1, 1, 64'h0);
    ctl_op(2'd3, 0, '0);
    // R6 EL3 trap and both undefined flavours
    sm_trap_en = 0;
    ctl_op(2'd2, 0, '0);
    mon_undef = 1;
    ctl_op(2'd2, 0, '0);
    mon_undef = 0; mon_undef_first = 1;
    ctl_op(2'd2, 0, '0);
    mon_undef_first = 0; el3_present = 0;
    ctl_op(2'd2, 1, 64'h0000_0000_0002_0005);
    // R8 guest reads over every class, good context
    el2_en = 1; el1_aa64 = 1; hcr_e2h = 0; hcr_tge = 0;
    for (int c = 0; c < 8; c++) begin
      for (int i = 0; i < 16; i++) begin
        req_valid = 1; req_kind = 1; req_el = 2'(i % 2);
        gr_class = 3'(c); gr_idx = 4'(i); hi_prio_exc = 0;
        step();
      end
    end
    // R12 wrong encoding ignored, then idle
    ctl_op(2'd3, 1, '1);
    req_enc = ENC ^ 16'h0001; req_wdata = 64'h0; req_write = 1;
    step();
    req_valid = 0;
    step();
    ctl_op(2'd3, 0, '0);
    // random mix
    for (int n = 0; n < 4000; n++) begin
      req_valid = ($urandom_range(0, 9) != 0);
      req_kind = $urandom_range(0, 1);
      req_write = $urandom_range(0, 1);
      req_enc = ($urandom_range(0, 9) != 0) ? ENC : 16'($urandom);
      req_wdata = {$urandom, $urandom};
      req_el = 2'($urandom_range(0, 3));
      gr_class = 3'($urandom_range(0, 7));
      gr_idx = 4'($urandom_range(0, 15));
      hi_prio_exc = ($urandom_range(0, 7) == 0);
      feat_present = ($urandom_range(0, 9) != 0);
      el2_en = ($urandom_range(0, 3) != 0);
      hcr_e2h = $urandom_range(0, 1);
      hcr_tge = $urandom_range(0, 1);
      el1_aa64 = ($urandom_range(0, 3) != 0);
      nv_bits = 3'($urandom_range(0, 7));
      el3_present = $urandom_range(0, 1);
      sm_trap_en = ($urandom_range(0, 3) != 0);
      mon_undef_first = ($urandom_range(0, 3) == 0);
      mon_undef = ($urandom_range(0, 3) == 0);
      step();
    end
    req_valid = 0;
    step();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(150000 * 10);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL R11: watchdog expired, actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule